// File: doc/BRIEF.md
# Congestion-Driven Compression Controller

This block decides whether the packets that cross one network interface of an on-chip network should be compressed. Compression costs encode and decode cycles. It therefore pays off only when packets would wait anyway. The block watches congestion at both ends of a path and turns compression on only while congestion is present.

On the transmit side it judges each packet as that packet leaves the interface buffer. It uses three tests and enables compression if any one of them holds. The first test is whether other packets are still queued behind this one. The second is whether the attached router has no free virtual channel. The third is whether the queuing delay, averaged over the last k injected packets, is above a threshold.

On the receive side it takes the injection timestamp carried by each arriving packet and subtracts the path's zero-load delay from the measured network delay. The result is the contention delay. It averages that contention delay per sending node over the last k packets from that sender. From the average it keeps one compression-status bit per sender. A control request addressed to a sender goes out only when that sender's status flips, so steady traffic produces no control messages. All timestamps are free-running counters, and every subtraction is taken modulo the counter width.

Top module: `cmpr_ctl`

## Requirements
- R1: The queuing delay of an injected packet is `(now - tx_enq_time) mod 2^TS_W`, so a wrapped counter still yields the true elapsed time.
- R2: While `tx_valid` is high and `ni_pending` is non-zero, `tx_compress` is high in the same cycle.
- R3: While `tx_valid` is high and `vc_free` is low, `tx_compress` is high in the same cycle.
- R4: While `tx_valid` is high, `tx_compress` is high if floor(sum of the queuing delays of this packet and the previous 2^K_LOG2-1 injected packets, divided by 2^K_LOG2) exceeds Q_THR (default 0). Before a packet has been injected, its delay counts as 0.
- R5: `tx_compress` is low whenever `tx_valid` is low. It is also low when none of the conditions in R2, R3 and R4 holds.
- R6: The contention delay of an arriving packet is `((now - rx_inj_time) mod 2^TS_W) - rx_zero_load`, clamped to 0 when the network delay is below the zero-load delay.
- R7: Each sender `s` has its own history of the contention delays of its last 2^K_LOG2 packets, with unfilled entries counted as 0. An arrival from `s` sets that sender's status to 1 when floor(window sum / 2^K_LOG2) > `cont_thr`, and to 0 otherwise.
- R8: One cycle after an arrival whose new status differs from the stored status, `ctl_valid` is high, `ctl_src` carries the sender and `ctl_enable` carries the new status (1 = compress). In every other cycle, `ctl_valid` is low.
- R9: After reset, every sender status is 0, every history is 0 and `ctl_valid` is low.
- R10: Cycles with `tx_valid` low do not enter the transmit history. Cycles with `rx_valid` low do not enter any receive history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | TS_W | Free-running time counter |
| tx_valid | input | 1 | A packet leaves the interface buffer this cycle |
| tx_enq_time | input | TS_W | Time at which that packet entered the buffer |
| ni_pending | input | OCC_W | Packets still queued behind it |
| vc_free | input | 1 | Router has at least one free virtual channel |
| tx_compress | output | 1 | Compress the leaving packet |
| rx_valid | input | 1 | A packet arrives this cycle |
| rx_src | input | SRC_W | Sending node of the arriving packet |
| rx_inj_time | input | TS_W | Injection timestamp carried by the packet |
| rx_zero_load | input | TS_W | Zero-load delay of the path from that sender |
| cont_thr | input | TS_W | Contention-delay threshold |
| ctl_valid | output | 1 | Status-change control request |
| ctl_src | output | SRC_W | Sender addressed by the request |
| ctl_enable | output | 1 | New compression status for that sender |

## Verification
The embedded assertions check four things on every cycle. Compression is never asked for without a packet. A non-empty buffer or a blocked router always forces compression. The contention delay never exceeds the raw network delay. Each control request matches the status just stored for its sender and appears only after an arrival. The windowed averages, the modular timestamp wraparound, the per-sender separation of histories and the exact set of cycles in which a status flips can only be shown by the bench's scenarios. The bench sweeps these with an arithmetic model of every history and compares the outputs on each packet.

// File: rtl/cmpr_pkg.sv
package cmpr_pkg;
   localparam int unsigned CMPR_MAX_TS_W = 32;

   function automatic logic [31:0] wrap_diff(input logic [31:0] later, input logic [31:0] earlier);
      return later - earlier;
   endfunction

   function automatic logic [31:0] floor_sub(input logic [31:0] a, input logic [31:0] b);
      return (a > b) ? (a - b) : 32'd0;
   endfunction
endpackage

// File: rtl/cmpr_dly_win.sv
module cmpr_dly_win #(
   parameter int unsigned DW = 8,
   parameter int unsigned KL = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] sample,
   output logic [DW-1:0] avg_incl
);
   localparam int unsigned K  = 1 << KL;
   localparam int unsigned SW = DW + KL;

   logic [DW-1:0] hist_q [K];
   logic [SW-1:0] sum_q;
   logic [SW-1:0] sum_nxt;

   assign sum_nxt  = sum_q - SW'(hist_q[K-1]) + SW'(sample);
   assign avg_incl = sum_nxt[SW-1:KL];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q <= '0;
         for (int i = 0; i < K; i++) hist_q[i] <= '0;
      end else if (push) begin
         sum_q     <= sum_nxt;
         hist_q[0] <= sample;
         for (int i = 1; i < K; i++) hist_q[i] <= hist_q[i-1];
      end
   end

   // R9
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> sum_q == '0);
endmodule

// File: rtl/cmpr_tx_judge.sv
module cmpr_tx_judge
   import cmpr_pkg::*;
#(
   parameter int unsigned TS_W  = 8,
   parameter int unsigned OCC_W = 4,
   parameter int unsigned K_LOG2 = 2,
   parameter int unsigned Q_THR = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  now,
   input  logic             tx_valid,
   input  logic [TS_W-1:0]  tx_enq_time,
   input  logic [OCC_W-1:0] ni_pending,
   input  logic             vc_free,
   output logic             tx_compress
);
   logic [TS_W-1:0] q_dly;
   logic [TS_W-1:0] q_avg;
   logic [31:0]     diff32;
   logic            late_hit;
   logic            occ_hit;

   assign diff32 = wrap_diff(32'(now), 32'(tx_enq_time));
   assign q_dly  = diff32[TS_W-1:0];

   cmpr_dly_win #(.DW(TS_W), .KL(K_LOG2)) q_win_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (tx_valid),
      .sample   (q_dly),
      .avg_incl (q_avg)
   );

   assign late_hit    = 32'(q_avg) > Q_THR;
   assign occ_hit     = (ni_pending != '0) || !vc_free;
   assign tx_compress = tx_valid && (occ_hit || late_hit);

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |-> !tx_compress);
   // R2
   backlog_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && ni_pending != '0) |-> tx_compress);
   // R3
   vc_block_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !vc_free) |-> tx_compress);
endmodule

// File: rtl/cmpr_rx_judge.sv
module cmpr_rx_judge
   import cmpr_pkg::*;
#(
   parameter int unsigned TS_W   = 8,
   parameter int unsigned N_SRC  = 4,
   parameter int unsigned K_LOG2 = 2,
   parameter int unsigned SRC_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  now,
   input  logic             rx_valid,
   input  logic [SRC_W-1:0] rx_src,
   input  logic [TS_W-1:0]  rx_inj_time,
   input  logic [TS_W-1:0]  rx_zero_load,
   input  logic [TS_W-1:0]  cont_thr,
   output logic             ctl_valid,
   output logic [SRC_W-1:0] ctl_src,
   output logic             ctl_enable
);
   logic [31:0]      net32;
   logic [31:0]      cont32;
   logic [TS_W-1:0]  net_dly;
   logic [TS_W-1:0]  cont_dly;
   logic [TS_W-1:0]  avg_v [N_SRC];
   logic [TS_W-1:0]  avg_sel;
   logic [N_SRC-1:0] stat_q;
   logic             new_st;
   logic             flip;

   assign net32    = wrap_diff(32'(now), 32'(rx_inj_time));
   assign net_dly  = net32[TS_W-1:0];
   assign cont32   = floor_sub(32'(net_dly), 32'(rx_zero_load));
   assign cont_dly = cont32[TS_W-1:0];

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      logic push_g;
      assign push_g = rx_valid && (32'(rx_src) == g);
      cmpr_dly_win #(.DW(TS_W), .KL(K_LOG2)) c_win_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (push_g),
         .sample   (cont_dly),
         .avg_incl (avg_v[g])
      );
   end

   assign avg_sel = avg_v[rx_src];
   assign new_st  = avg_sel > cont_thr;
   assign flip    = rx_valid && (new_st != stat_q[rx_src]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q     <= '0;
         ctl_valid  <= 1'b0;
         ctl_src    <= '0;
         ctl_enable <= 1'b0;
      end else begin
         ctl_valid <= flip;
         if (rx_valid) stat_q[rx_src] <= new_st;
         if (flip) begin
            ctl_src    <= rx_src;
            ctl_enable <= new_st;
         end
      end
   end

   // R6
   cont_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> cont_dly <= net_dly);
   // R8
   ctl_matches_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_valid |-> stat_q[ctl_src] == ctl_enable);
endmodule

// File: rtl/cmpr_ctl.sv
module cmpr_ctl #(
   parameter int unsigned TS_W   = 8,
   parameter int unsigned OCC_W  = 4,
   parameter int unsigned N_SRC  = 4,
   parameter int unsigned K_LOG2 = 2,
   parameter int unsigned Q_THR  = 0,
   localparam int unsigned SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  now,
   input  logic             tx_valid,
   input  logic [TS_W-1:0]  tx_enq_time,
   input  logic [OCC_W-1:0] ni_pending,
   input  logic             vc_free,
   output logic             tx_compress,
   input  logic             rx_valid,
   input  logic [SRC_W-1:0] rx_src,
   input  logic [TS_W-1:0]  rx_inj_time,
   input  logic [TS_W-1:0]  rx_zero_load,
   input  logic [TS_W-1:0]  cont_thr,
   output logic             ctl_valid,
   output logic [SRC_W-1:0] ctl_src,
   output logic             ctl_enable
);
   if (TS_W < 2 || TS_W > cmpr_pkg::CMPR_MAX_TS_W) begin : g_bad_ts
      $error("cmpr_ctl: TS_W out of range");
   end
   if (K_LOG2 < 1 || K_LOG2 > 6) begin : g_bad_k
      $error("cmpr_ctl: K_LOG2 must lie in 1..6");
   end
   if (N_SRC < 1 || N_SRC > 64) begin : g_bad_n
      $error("cmpr_ctl: N_SRC must lie in 1..64");
   end

   cmpr_tx_judge #(
      .TS_W(TS_W), .OCC_W(OCC_W), .K_LOG2(K_LOG2), .Q_THR(Q_THR)
   ) tx_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .now         (now),
      .tx_valid    (tx_valid),
      .tx_enq_time (tx_enq_time),
      .ni_pending  (ni_pending),
      .vc_free     (vc_free),
      .tx_compress (tx_compress)
   );

   cmpr_rx_judge #(
      .TS_W(TS_W), .N_SRC(N_SRC), .K_LOG2(K_LOG2), .SRC_W(SRC_W)
   ) rx_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .now          (now),
      .rx_valid     (rx_valid),
      .rx_src       (rx_src),
      .rx_inj_time  (rx_inj_time),
      .rx_zero_load (rx_zero_load),
      .cont_thr     (cont_thr),
      .ctl_valid    (ctl_valid),
      .ctl_src      (ctl_src),
      .ctl_enable   (ctl_enable)
   );

   // R8
   ctl_after_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_valid |-> $past(rx_valid));
endmodule

// File: tb/cmpr_ctl_tb_top.sv
module cmpr_ctl_tb_top;
   localparam int TS_W = 8;
   localparam int K = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] now = '0;
   logic       tx_valid = 1'b0;
   logic [7:0] tx_enq_time = '0;
   logic [3:0] ni_pending = '0;
   logic       vc_free = 1'b1;
   logic       tx_compress;
   logic       rx_valid = 1'b0;
   logic [1:0] rx_src = '0;
   logic [7:0] rx_inj_time = '0;
   logic [7:0] rx_zero_load = '0;
   logic [7:0] cont_thr = 8'd8;
   logic       ctl_valid;
   logic [1:0] ctl_src;
   logic       ctl_enable;

   int n_chk = 0;
   int n_bad = 0;
   int tx_h [K];
   int rx_h [4][K];
   int stat [4];

   always #10 clk = ~clk;

   cmpr_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .now(now),
      .tx_valid(tx_valid), .tx_enq_time(tx_enq_time), .ni_pending(ni_pending),
      .vc_free(vc_free), .tx_compress(tx_compress),
      .rx_valid(rx_valid), .rx_src(rx_src), .rx_inj_time(rx_inj_time),
      .rx_zero_load(rx_zero_load), .cont_thr(cont_thr),
      .ctl_valid(ctl_valid), .ctl_src(ctl_src), .ctl_enable(ctl_enable)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   always @(posedge clk) now <= now + 8'd1;

   initial begin
      for (int i = 0; i < K; i++) tx_h[i] = 0;
      for (int s = 0; s < 4; s++) begin
         stat[s] = 0;
         for (int i = 0; i < K; i++) rx_h[s][i] = 0;
      end
      repeat (3) @(negedge clk);
      // R9: outputs are quiet while reset is held
      chk(ctl_valid == 1'b0, "R9 ctl in reset", int'(ctl_valid), 0);
      chk(tx_compress == 1'b0, "R9 tx in reset", int'(tx_compress), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ctl_valid == 1'b0, "R9 ctl after reset", int'(ctl_valid), 0);

      // transmit side sweep: R1 R2 R3 R4 R5 R10
      for (int i = 0; i < 360; i++) begin
         int d, sum, avg, occ;
         bit vc, valid, exp;
         valid = (i % 6) != 5;
         if ((i / 24) % 3 == 0) d = 0;
         else d = (i * 13) % 23;
         occ = ((i / 7) % 5 == 0) ? (i % 3) + 1 : 0;
         vc  = ((i / 11) % 4) != 1;
         if ((i / 24) % 3 == 0) begin occ = 0; vc = 1'b1; end
         tx_valid    = valid;
         tx_enq_time = 8'(int'(now) - (valid ? d : 200));
         ni_pending  = 4'(occ);
         vc_free     = vc;
         #2;
         if (valid) begin
            sum = d;
            for (int j = 0; j < K - 1; j++) sum += tx_h[j];
            avg = sum / K;
            exp = (occ != 0) || !vc || (avg > 0);
            if (occ != 0)
               chk(tx_compress == 1'b1, "R2 backlog", int'(tx_compress), 1);
            else if (!vc)
               chk(tx_compress == 1'b1, "R3 no vc", int'(tx_compress), 1);
            else if (avg > 0)
               chk(tx_compress == exp, "R4 R1 avg delay", int'(tx_compress), int'(exp));
            else
               chk(tx_compress == exp, "R5 uncongested", int'(tx_compress), int'(exp));
            for (int j = K - 1; j > 0; j--) tx_h[j] = tx_h[j-1];
            tx_h[0] = d;
         end else begin
            chk(tx_compress == 1'b0, "R5 R10 idle", int'(tx_compress), 0);
         end
         @(negedge clk);
      end
      tx_valid = 1'b0;

      // receive side sweep: R6 R7 R8 R10
      for (int i = 0; i < 480; i++) begin
         int s, net, zl, c, sum, avg, nst;
         bit valid, exp_ctl;
         valid = (i % 7) != 6;
         s   = (i * 3 + i / 8) % 4;
         net = ((i / 12 + s) % 2 == 1) ? 30 + (i % 9) : (i % 5);
         zl  = (i % 4) * 2;
         cont_thr = (i < 240) ? 8'd8 : 8'd20;
         rx_valid     = valid;
         rx_src       = 2'(s);
         rx_inj_time  = 8'(int'(now) - net);
         rx_zero_load = 8'(zl);
         exp_ctl = 1'b0;
         nst = 0;
         if (valid) begin
            c = (net > zl) ? net - zl : 0;
            sum = c;
            for (int j = 0; j < K - 1; j++) sum += rx_h[s][j];
            avg = sum / K;
            nst = (avg > int'(cont_thr)) ? 1 : 0;
            exp_ctl = (nst != stat[s]);
            stat[s] = nst;
            for (int j = K - 1; j > 0; j--) rx_h[s][j] = rx_h[s][j-1];
            rx_h[s][0] = c;
         end
         @(negedge clk);
         rx_valid = 1'b0;
         chk(ctl_valid == exp_ctl, "R8 R7 R6 ctl strobe", int'(ctl_valid), int'(exp_ctl));
         if (exp_ctl) begin
            chk(ctl_src == 2'(s), "R8 ctl src", int'(ctl_src), s);
            chk(ctl_enable == nst[0], "R7 new status", int'(ctl_enable), nst);
         end
      end
      @(negedge clk);
      chk(ctl_valid == 1'b0, "R10 no arrival", int'(ctl_valid), 0);
      finish_run();
   end
endmodule